// File: doc/BRIEF.md
# Serial Two-Capacitor SAR Conversion Sequencer

This block is the digital control sequencer of a 10-bit successive-approximation converter. Its DAC has only two equal capacitors and works serially. A charge-holding capacitor (C2) is first precharged to the reference or to ground. It is then shorted to a second capacitor (C1), so each shared voltage halves the previous value and adds half of the newest bit. Because of this, a trial level with k bits takes k precharge/share pairs. The sequencer builds every trial level from scratch, one stage per bit, most significant bit first.

A one-cycle start request begins a conversion. A stage counter and a step counter, both twisted-ring (Johnson) counters, run as a nested loop. The outer counter picks the bit being decided. The inner counter walks through the bits applied inside that stage. At the end of each stage the comparator output is sampled into the result. After the last stage a done pulse is raised and the 10-bit code stays on the output until the next start. The busy output also acts as the enable for the local conversion clock.

Top module: `sar2cap_seq`

## Requirements
- R1: While reset is held, and after its release, busy_o, done_o, all four capacitor controls and result_o are all 0.
- R2: A start accepted while idle gives exactly N(N+1) = 110 consecutive busy cycles. Stage k (k = 1..N) takes 2k of those cycles.
- R3: Each busy cycle is either a precharge cycle or a share cycle, and the two alternate, beginning with precharge. A precharge cycle raises exactly one of c2_chg_o (applied bit 1) and c2_dchg_o (applied bit 0). A share cycle raises share_o alone.
- R4: c1_rst_o is raised only in the first precharge cycle of each stage, so it appears exactly N = 10 times per conversion and never together with share_o.
- R5: In stage k the bits applied are taken from least to most significant. The first is the trial bit (value 1, result position N-k). After it come the already decided bits at positions N-k+1 up to N-1, so the MSB is applied last. Each conversion therefore raises c2_chg_o once per stage for the trial bit plus once for each decided 1 bit applied.
- R6: cmp_i is sampled in the last share cycle of stage k and written to result bit N-k. A value of 1 (input at or above the shared voltage) keeps the bit and 0 clears it. With an ideal capacitor pair, an input v (in units of Vref/2048) yields the code min(floor(v/2), 1023).
- R7: done_o is high for exactly one cycle, in the first cycle after the last busy cycle. busy_o is low in that cycle.
- R8: Accepting a start clears result_o to 0. After done_o, result_o holds the final code unchanged while no new start is accepted.
- R9: start_i is ignored while busy: a start pulse in the middle of a conversion neither shortens nor restarts it, and does not alter its result.
- R10: While idle, no capacitor control (c2_chg_o, c2_dchg_o, c1_rst_o, share_o) is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, acted on only while idle |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the shared DAC voltage |
| busy_o | output | 1 | Conversion in progress; also the clock enable of the local oscillator |
| c2_chg_o | output | 1 | Precharge C2 to the reference (applied bit 1) |
| c2_dchg_o | output | 1 | Discharge C2 to ground (applied bit 0) |
| c1_rst_o | output | 1 | Discharge C1 to ground at the start of a stage |
| share_o | output | 1 | Connect C1 and C2 for charge sharing |
| done_o | output | 1 | One-cycle pulse when the code is complete |
| result_o | output | 10 | Converted code, held until the next start |

## Verification
The bench couples the sequencer to an exact integer model of the two capacitors. It then drives inputs at the code edges: zero, one LSB below and above a step, mid-scale, the full-scale clamp, and alternating bit patterns. Each of these gives a known code and a known count of charge pulses.

A sequencer that applied the bits in the wrong order, or reused C1 without its reset, would produce wrong codes for most inputs. A wrong stage length would show up in the busy-cycle count and the share count.

Directed cases cover the remaining corners. A start pulse in the middle of a conversion catches a design that restarts. A long idle wait after done catches a result that drifts or controls that fire while idle. A reset in the middle of a conversion catches state that survives reset.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Sub-cycle of one redistribution step
    typedef enum logic {
        PH_PRE   = 1'b0,  // C2 precharge (and C1 reset on the first step)
        PH_SHARE = 1'b1   // C1/C2 connected
    } phase_e;

    // Registered control state of the sequencer
    typedef struct packed {
        logic   busy;
        phase_e phase;
        logic   done;
    } ctl_t;

endpackage

// File: rtl/sar_johnson_ctr.sv
module sar_johnson_ctr #(
    parameter int W  = 5,
    parameter int IW = $clog2(2 * W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [IW-1:0] idx_o
);

    localparam int NSTATES = 2 * W;

    logic [W-1:0] pat_d, pat_q;
    logic         legal;

    // Ones fill from bit 0 upward, then drain from bit 0 upward.
    function automatic logic [IW-1:0] pat2idx(input logic [W-1:0] p);
        int c;
        c = $countones(p);
        if (!p[W-1]) return IW'(c);
        return IW'(NSTATES - c);
    endfunction

    function automatic logic [W-1:0] idx2pat(input logic [IW-1:0] i);
        logic [W-1:0] p;
        for (int b = 0; b < W; b++) begin
            if (int'(i) < W) p[b] = (b < int'(i));
            else             p[b] = (b >= int'(i) - W);
        end
        return p;
    endfunction

    always_comb begin
        legal = (idx2pat(pat2idx(pat_q)) == pat_q);
        pat_d = pat_q;
        if (clr_i || !legal) pat_d = '0;          // reload also repairs corrupted state
        else if (inc_i)      pat_d = {pat_q[W-2:0], ~pat_q[W-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end

    assign idx_o = pat2idx(pat_q);

    // R2: counter only ever holds a twisted-ring pattern
    a_r2_pattern_legal: assert property (@(posedge clk) disable iff (!rst_n)
        legal);

    // R2: one increment advances the count by exactly one state
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (int'(idx_o) == (int'($past(idx_o)) + 1) % NSTATES));

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int N  = 10,
    parameter int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [PW-1:0] pos_i,
    input  logic          bit_i,
    output logic [N-1:0]  q_o
);

    logic [N-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (clr_i)     res_d = '0;
        else if (we_i) res_d[pos_i] = bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign q_o = res_q;

    // R6: one decision touches at most one result bit
    a_r6_single_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> ($countones(q_o ^ $past(q_o)) <= 1));

    // R8: without a write or clear the code holds
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/sar2cap_seq.sv
module sar2cap_seq #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         busy_o,
    output logic         c2_chg_o,
    output logic         c2_dchg_o,
    output logic         c1_rst_o,
    output logic         share_o,
    output logic         done_o,
    output logic [N-1:0] result_o
);

    import sar_seq_pkg::*;

    localparam int JW = (N + 1) / 2;      // flops per Johnson counter
    localparam int IW = $clog2(2 * JW);   // decoded index width
    localparam int PW = $clog2(N);        // result bit position width

    ctl_t          ctl_d, ctl_q;
    logic [IW-1:0] stage_idx, step_idx;
    logic          stage_clr, stage_inc, step_clr, step_inc;
    logic          res_clr, res_we;
    logic [PW-1:0] res_pos;
    logic [N-1:0]  res_q;
    logic          pre_cyc, share_cyc, applied_bit, first_step, stage_end, last_stage;

    // Outer loop: which bit is being decided
    sar_johnson_ctr #(.W(JW), .IW(IW)) u_stage_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (stage_clr),
        .inc_i (stage_inc),
        .idx_o (stage_idx)
    );

    // Inner loop: which bit is applied inside the stage
    sar_johnson_ctr #(.W(JW), .IW(IW)) u_step_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (step_clr),
        .inc_i (step_inc),
        .idx_o (step_idx)
    );

    sar_result_reg #(.N(N), .PW(PW)) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (res_clr),
        .we_i  (res_we),
        .pos_i (res_pos),
        .bit_i (cmp_i),
        .q_o   (res_q)
    );

    always_comb begin
        int ap;
        pre_cyc    = ctl_q.busy && (ctl_q.phase == PH_PRE);
        share_cyc  = ctl_q.busy && (ctl_q.phase == PH_SHARE);
        first_step = (step_idx == '0);
        stage_end  = share_cyc && (step_idx == stage_idx);
        last_stage = (stage_idx == IW'(N - 1));

        // step s of stage k applies result position N-k+s; s=0 is the trial bit
        ap = N - 1 - int'(stage_idx) + int'(step_idx);
        if (first_step)              applied_bit = 1'b1;
        else if (ap >= 0 && ap < N)  applied_bit = res_q[PW'(ap)];
        else                         applied_bit = 1'b0;

        res_pos   = PW'(N - 1 - int'(stage_idx));
        res_we    = stage_end;
        res_clr   = 1'b0;
        stage_clr = 1'b0;
        stage_inc = 1'b0;
        step_clr  = 1'b0;
        step_inc  = 1'b0;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;

        if (!ctl_q.busy) begin
            if (start_i) begin
                ctl_d.busy  = 1'b1;
                ctl_d.phase = PH_PRE;
                res_clr     = 1'b1;
                stage_clr   = 1'b1;
                step_clr    = 1'b1;
            end
        end else begin
            ctl_d.phase = (ctl_q.phase == PH_PRE) ? PH_SHARE : PH_PRE;
            if (stage_end) begin
                step_clr = 1'b1;
                if (last_stage) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    stage_clr  = 1'b1;
                end else begin
                    stage_inc = 1'b1;
                end
            end else if (share_cyc) begin
                step_inc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.busy  <= 1'b0;
            ctl_q.phase <= PH_PRE;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = ctl_q.busy;
    assign done_o    = ctl_q.done;
    assign c2_chg_o  = pre_cyc && applied_bit;
    assign c2_dchg_o = pre_cyc && !applied_bit;
    assign c1_rst_o  = pre_cyc && first_step;
    assign share_o   = share_cyc;
    assign result_o  = res_q;

    // R3: C2 is never driven while connected to C1
    a_r3_no_drive_while_sharing: assert property (@(posedge clk) disable iff (!rst_n)
        !(share_o && (c2_chg_o || c2_dchg_o)));

    // R3: charge and discharge are exclusive
    a_r3_chg_dchg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(c2_chg_o && c2_dchg_o));

    // R3: a share cycle always follows a precharge cycle
    a_r3_share_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        share_o |-> $past(c2_chg_o || c2_dchg_o));

    // R4: C1 reset only alongside a C2 precharge
    a_r4_c1_reset_in_pre: assert property (@(posedge clk) disable iff (!rst_n)
        c1_rst_o |-> (c2_chg_o || c2_dchg_o));

    // R7: done is a single-cycle pulse outside busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // R8: idle without start keeps the code
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));

    // R9: a conversion only ends at the last decision
    a_r9_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(stage_end && last_stage)) |=> busy_o);

    // R10: no capacitor activity while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(c2_chg_o || c2_dchg_o || c1_rst_o || share_o));

endmodule

// File: tb/sar2cap_seq_tb_top.sv
`timescale 1ns/1ps
module sar2cap_seq_tb_top;

    localparam int N     = 10;
    localparam int NVEC  = 12;
    localparam int FULL  = 2048;   // Vref in model units
    localparam int VIN [NVEC] = '{0, 1, 2, 3, 1023, 1024, 2047, 2046, 1366, 682, 1000, 1500};
    localparam int EXPV[NVEC] = '{0, 0, 1, 1, 511,  512,  1023, 1023, 683,  341, 500,  750};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i;
    logic         busy_o, c2_chg_o, c2_dchg_o, c1_rst_o, share_o, done_o;
    logic [N-1:0] result_o;

    int checks = 0;
    int fails  = 0;
    int vin    = 0;

    always #4 clk = ~clk;   // 125 MHz

    sar2cap_seq #(.N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .busy_o    (busy_o),
        .c2_chg_o  (c2_chg_o),
        .c2_dchg_o (c2_dchg_o),
        .c1_rst_o  (c1_rst_o),
        .share_o   (share_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    // Ideal two-capacitor model, in units of Vref/2048
    int   c1v = 0, c2v = 0;
    logic s_chg = 0, s_dchg = 0, s_rst = 0, s_share = 0;

    always @(negedge clk) begin
        s_chg   <= c2_chg_o;
        s_dchg  <= c2_dchg_o;
        s_rst   <= c1_rst_o;
        s_share <= share_o;
    end

    always @(posedge clk) begin
        if (s_rst)       c1v <= 0;
        if (s_chg)       c2v <= FULL;
        else if (s_dchg) c2v <= 0;
        if (s_share) begin
            c1v <= (c1v + c2v) / 2;
            c2v <= (c1v + c2v) / 2;
        end
    end

    assign cmp_i = (vin >= (c1v + c2v) / 2);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_chg(input int code);
        int n = 0;
        for (int k = 1; k <= N; k++) begin
            n++;                                   // trial bit
            for (int p = N - k + 1; p < N; p++) n += (code >> p) & 1;
        end
        return n;
    endfunction

    task automatic run_conv(input int v, input int exp, input bit mid_start);
        int  cyc = 0, shares = 0, rsts = 0, chgs = 0, bad = 0, guard = 0;
        bit  prev_pre = 0;
        vin = v;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(result_o == '0, "R8 start clears result", int'(result_o), 0);
        while (!done_o && guard < 400) begin
            if (busy_o) begin
                cyc++;
                if (share_o) shares++;
                if (c1_rst_o) rsts++;
                if (c2_chg_o) chgs++;
                if (($countones({c2_chg_o, c2_dchg_o, share_o}) != 1) ||
                    (share_o && !prev_pre) || (!share_o && cyc > 1 && prev_pre) ||
                    (c1_rst_o && share_o))
                    bad++;
                prev_pre = c2_chg_o || c2_dchg_o;
            end
            start_i = (mid_start && cyc == 40);
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        chk(result_o == N'(exp), "R6 converted code", int'(result_o), exp);
        chk(cyc == N * (N + 1), "R2 busy cycles", cyc, N * (N + 1));
        chk(shares == N * (N + 1) / 2 && bad == 0, "R3 precharge/share protocol", shares + 1000 * bad, N * (N + 1) / 2);
        chk(rsts == N, "R4 C1 resets per conversion", rsts, N);
        chk(chgs == exp_chg(exp), "R5 charge pulses from bit order", chgs, exp_chg(exp));
        chk(!busy_o && done_o, "R7 done with busy low", int'({busy_o, done_o}), 1);
        @(negedge clk);
        chk(!done_o, "R7 done lasts one cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] held;
        int quiet;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, c2_chg_o, c2_dchg_o, c1_rst_o, share_o} == '0 && result_o == '0,
            "R1 outputs in reset", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, c2_chg_o, c2_dchg_o, c1_rst_o, share_o} == '0 && result_o == '0,
            "R1 outputs after reset release", int'({busy_o, done_o}), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) run_conv(VIN[i], EXPV[i], 1'b0);

        // R8 / R10: idle hold after a conversion
        held  = result_o;
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            vin = (i * 97) % FULL;
            if (result_o != held) quiet++;
            if (c2_chg_o || c2_dchg_o || c1_rst_o || share_o || busy_o) quiet += 100;
            @(negedge clk);
        end
        chk(result_o == held && quiet == 0, "R8 result held while idle", int'(result_o), int'(held));
        chk(quiet < 100, "R10 no controls while idle", quiet, 0);

        // R9: start pulse mid-conversion is ignored
        run_conv(1366, 683, 1'b1);
        chk(result_o == N'(683), "R9 result unaffected by mid start", int'(result_o), 683);

        // R1: reset in the middle of a conversion
        vin = 900;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o, c2_chg_o, c2_dchg_o, c1_rst_o, share_o} == '0 && result_o == '0,
            "R1 mid-conversion reset", int'({busy_o, result_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_conv(900, 450, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule